// File: doc/BRIEF.md
# Symmetric Space-Vector PWM Generator

This block drives the six gate signals of a two-level, three-phase voltage-source inverter. A free-running tick counter divides time into fixed switching periods of `PERIOD` ticks. In each period the block plays out the two active vectors on either side of the voltage reference. It splits the leftover zero time between the all-low vector and the all-high vector, and the resulting pattern is mirror-symmetric about the middle of the period. The upstream controller supplies a sector number and two dwell times, counted in ticks, for the right-hand and left-hand active vectors. Each leg drives its upper and lower switch as a complementary pair. A dead band of `DEAD` ticks keeps both switches off after every change of leg state.

Commands come in over a valid/ready stream. `cmd_ready` is high for exactly one tick per period, in the last tick. A command is accepted in a tick where `cmd_valid` and `cmd_ready` are both high, and it takes effect from the first tick of the next period. The source must hold the command fields stable while `cmd_valid` is high and the command has not been accepted. It may keep `cmd_valid` high for as many periods as it needs. When no command is accepted, the previous command repeats unchanged, so the pattern never changes in the middle of a period.

Top module: `svpwm_gen`

## Requirements
- R1: Vector codes give the upper-switch state of legs C,B,A as bits 2,1,0: V0=000, V1=001, V2=011, V3=010, V4=110, V5=100, V6=101, V7=111.
- R2: For sector k (1..6), the right-hand vector Va is Vk with dwell `cmd_ta`, and the left-hand vector Vb is V(k mod 6 + 1) with dwell `cmd_tb`.
- R3: Each period plays V0 for q1, then the first vector for ⌊L1/2⌋, then the second vector for ⌊L2/2⌋, then V7 for z7, then the second vector for the rest of L2, then the first vector for the rest of L1, then V0 for the remaining ticks. In odd sectors the first vector is Va and the second is Vb. In even sectors the order is swapped, so that the vector next to V0 always has a single high bit. Segments of zero length are skipped.
- R4: The zero time is T0 = PERIOD − Ta − Tb, with z7 = ⌊T0/2⌋ and q1 = ⌊(T0 − z7)/2⌋. The trailing V0 takes T0 − z7 − q1.
- R5: If Ta + Tb > PERIOD, then Ta becomes ⌊Ta·PERIOD/(Ta+Tb)⌋, Tb becomes PERIOD − Ta, and T0 is 0.
- R6: A sector value of 0 or 7 is accepted but treated as Ta = Tb = 0, which gives a zero-vector-only period.
- R7: `cmd_ready` is high only in the last tick of each period. A command is taken on valid and ready and applies from the next tick. Without a new command, the previous command repeats.
- R8: The gate outputs follow the wanted leg state with one clock of latency. After any change of a leg's wanted state, both switches of that leg stay off for `DEAD` ticks before the new side turns on.
- R9: Reset drives all six gates low and restarts the period. The reset command is sector 1 with Ta = Tb = 0.
- R10: The upper and lower gate of a leg are never on in the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | High in the last tick of a period |
| cmd_sector | input | 3 | Sector number 1..6 |
| cmd_ta | input | W | Right-hand vector dwell, ticks |
| cmd_tb | input | W | Left-hand vector dwell, ticks |
| gate_hi | output | 3 | Upper switches, bits C,B,A |
| gate_lo | output | 3 | Lower switches, bits C,B,A |

## Verification
Two things can happen in the same tick: a new command takes over at the period boundary, and a leg's dead-band countdown is still running, or a leg changes state. This case is provoked in two ways. Some commands change the vector that ends one period and starts the next. Others use dwell times shorter than the dead band, so that state changes pile up across the boundary. The result is judged tick by tick against a bench model of the pattern and dead-band rules, which also confirms that no leg ever has both gates on.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  typedef enum logic [2:0] {
    SEG_ZLEAD, SEG_F1, SEG_S1, SEG_ZMID, SEG_S2, SEG_F2, SEG_ZTAIL
  } seg_e;

  // leg state per hexagon vector, bit0 = leg A
  function automatic logic [2:0] vec_code(input logic [2:0] idx);
    logic [2:0] c;
    case (idx)
      3'd0:    c = 3'b000;
      3'd1:    c = 3'b001;
      3'd2:    c = 3'b011;
      3'd3:    c = 3'b010;
      3'd4:    c = 3'b110;
      3'd5:    c = 3'b100;
      3'd6:    c = 3'b101;
      default: c = 3'b111;
    endcase
    return c;
  endfunction

  function automatic logic [2:0] next_sec(input logic [2:0] s);
    return (s == 3'd6) ? 3'd1 : s + 3'd1;
  endfunction

endpackage

// File: rtl/svpwm_cmd_latch.sv
module svpwm_cmd_latch
  import svpwm_pkg::*;
#(
  parameter int W      = 10,
  parameter int PERIOD = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [2:0]          sector,
  input  logic [W-1:0]        ta,
  input  logic [W-1:0]        tb,
  output logic [2:0]          act_sector,
  output logic [2:0]          code_first,
  output logic [2:0]          code_second,
  output logic [5:0][W-1:0]   bnd
);
  localparam int XW  = W + 1;
  localparam int MW  = 2 * W + 2;
  localparam int RZ7 = PERIOD / 2;
  localparam int RQ1 = (PERIOD - RZ7) / 2;

  logic             sec_ok, over;
  logic [2:0]       sec_eff, sec_b;
  logic [XW-1:0]    ta_e, tb_e, sum, ta_c, tb_c, t0;
  logic [XW-1:0]    len_f, len_s, f1, f2, s1, s2, z7, q1;
  logic [MW-1:0]    prod, quo;
  logic [5:0][W-1:0] bnd_n;

  always_comb begin
    sec_ok  = (sector != 3'd0) && (sector != 3'd7);
    sec_eff = sec_ok ? sector : 3'd1;
    sec_b   = next_sec(sec_eff);
    ta_e    = sec_ok ? XW'(ta) : '0;
    tb_e    = sec_ok ? XW'(tb) : '0;
    sum     = ta_e + tb_e;
    over    = sum > XW'(PERIOD);
    // overmodulation: keep the Ta:Tb ratio, fill the whole period
    prod    = MW'(ta_e) * MW'(PERIOD);
    quo     = over ? prod / MW'(sum) : '0;
    ta_c    = over ? XW'(quo) : ta_e;
    tb_c    = over ? XW'(PERIOD) - ta_c : tb_e;
    t0      = XW'(PERIOD) - ta_c - tb_c;
    // single-high-bit vector sits next to V0
    len_f   = sec_eff[0] ? ta_c : tb_c;
    len_s   = sec_eff[0] ? tb_c : ta_c;
    f1      = len_f >> 1;
    f2      = len_f - f1;
    s1      = len_s >> 1;
    s2      = len_s - s1;
    z7      = t0 >> 1;
    q1      = (t0 - z7) >> 1;
    bnd_n[0] = W'(q1);
    bnd_n[1] = bnd_n[0] + W'(f1);
    bnd_n[2] = bnd_n[1] + W'(s1);
    bnd_n[3] = bnd_n[2] + W'(z7);
    bnd_n[4] = bnd_n[3] + W'(s2);
    bnd_n[5] = bnd_n[4] + W'(f2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_sector  <= 3'd1;
      code_first  <= 3'b001;
      code_second <= 3'b011;
      bnd[0]      <= W'(RQ1);
      bnd[1]      <= W'(RQ1);
      bnd[2]      <= W'(RQ1);
      bnd[3]      <= W'(RQ1 + RZ7);
      bnd[4]      <= W'(RQ1 + RZ7);
      bnd[5]      <= W'(RQ1 + RZ7);
    end else if (load) begin
      act_sector  <= sec_eff;
      code_first  <= vec_code(sec_eff[0] ? sec_eff : sec_b);
      code_second <= vec_code(sec_eff[0] ? sec_b : sec_eff);
      bnd         <= bnd_n;
    end
  end

endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq
  import svpwm_pkg::*;
#(
  parameter int W      = 10,
  parameter int PERIOD = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        code_first,
  input  logic [2:0]        code_second,
  input  logic [5:0][W-1:0] bnd,
  output logic              at_end,
  output logic [2:0]        want
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;
  logic [W-1:0]  pos;
  seg_e          seg;

  always_comb begin
    pos    = W'(cnt);
    at_end = (cnt == CW'(PERIOD - 1));
    if      (pos < bnd[0]) seg = SEG_ZLEAD;
    else if (pos < bnd[1]) seg = SEG_F1;
    else if (pos < bnd[2]) seg = SEG_S1;
    else if (pos < bnd[3]) seg = SEG_ZMID;
    else if (pos < bnd[4]) seg = SEG_S2;
    else if (pos < bnd[5]) seg = SEG_F2;
    else                   seg = SEG_ZTAIL;
    case (seg)
      SEG_F1, SEG_F2: want = code_first;
      SEG_S1, SEG_S2: want = code_second;
      SEG_ZMID:       want = 3'b111;
      default:        want = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/svpwm_deadband.sv
module svpwm_deadband #(
  parameter int DEAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic hi,
  output logic lo
);
  localparam int CDW = $clog2(DEAD + 1);

  logic           applied;
  logic [CDW-1:0] dc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      applied <= 1'b0;
      dc      <= CDW'(DEAD);
    end else if (want != applied) begin
      applied <= want;
      dc      <= CDW'(DEAD);
    end else if (dc != '0) begin
      dc <= dc - 1'b1;
    end
  end

  assign hi = applied  && (dc == '0);
  assign lo = !applied && (dc == '0);

endmodule

// File: rtl/svpwm_gen.sv
module svpwm_gen #(
  parameter int W      = 10,
  parameter int PERIOD = 100,
  parameter int DEAD   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [2:0]   cmd_sector,
  input  logic [W-1:0] cmd_ta,
  input  logic [W-1:0] cmd_tb,
  output logic [2:0]   gate_hi,
  output logic [2:0]   gate_lo
);
  logic              at_end;
  logic [2:0]        act_sector, code_first, code_second, want;
  logic [5:0][W-1:0] bnd;

  assign cmd_ready = at_end;

  svpwm_cmd_latch #(.W(W), .PERIOD(PERIOD)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid && at_end),
    .sector(cmd_sector), .ta(cmd_ta), .tb(cmd_tb),
    .act_sector(act_sector), .code_first(code_first),
    .code_second(code_second), .bnd(bnd)
  );

  svpwm_seq #(.W(W), .PERIOD(PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .code_first(code_first),
    .code_second(code_second), .bnd(bnd), .at_end(at_end), .want(want)
  );

  for (genvar g = 0; g < 3; g++) begin : g_leg
    svpwm_deadband #(.DEAD(DEAD)) u_db (
      .clk(clk), .rst_n(rst_n), .want(want[g]),
      .hi(gate_hi[g]), .lo(gate_lo[g])
    );
  end

endmodule

// File: rtl/svpwm_chk.sv
module svpwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic [2:0] act_sector
);
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 3'b000); // R10

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R9

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(gate_lo) & gate_hi) == 3'b000) && (($past(gate_hi) & gate_lo) == 3'b000)); // R8

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> !cmd_ready); // R7

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(act_sector)); // R7

endmodule

bind svpwm_gen svpwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .act_sector(act_sector)
);

// File: tb/tb_svpwm_gen.sv
module tb_svpwm_gen;
  localparam int W    = 10;
  localparam int P    = 100;
  localparam int DEAD = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_sector = 3'd0;
  logic [W-1:0] cmd_ta = '0;
  logic [W-1:0] cmd_tb = '0;
  logic [2:0]   gate_hi, gate_lo;

  int n_run = 0;
  int n_fail = 0;
  string tag = "R9";

  // bench model state
  int m_cnt;
  int m_b[6];
  logic [2:0] m_first, m_second;
  logic [2:0] m_app;
  int m_dc[3];

  always #4 clk = ~clk;

  svpwm_gen #(.W(W), .PERIOD(P), .DEAD(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sector(cmd_sector), .cmd_ta(cmd_ta), .cmd_tb(cmd_tb),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  function automatic logic [2:0] code_of(int v); // R1 table
    case (v)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b011; 3: return 3'b010;
      4: return 3'b110; 5: return 3'b100; 6: return 3'b101; default: return 3'b111;
    endcase
  endfunction

  task automatic model_latch(int sec, int ta, int tb);
    int t0, vb, lf, ls, f1, s1, z7, q1;
    if (sec < 1 || sec > 6) begin sec = 1; ta = 0; tb = 0; end // R6
    if (ta + tb > P) begin ta = ta * P / (ta + tb); tb = P - ta; end // R5
    t0 = P - ta - tb; // R4
    vb = (sec == 6) ? 1 : sec + 1; // R2
    if (sec % 2 == 1) begin
      m_first = code_of(sec); m_second = code_of(vb); lf = ta; ls = tb;
    end else begin
      m_first = code_of(vb); m_second = code_of(sec); lf = tb; ls = ta;
    end
    f1 = lf / 2; s1 = ls / 2; z7 = t0 / 2; q1 = (t0 - z7) / 2;
    m_b[0] = q1;          m_b[1] = m_b[0] + f1;
    m_b[2] = m_b[1] + s1; m_b[3] = m_b[2] + z7;
    m_b[4] = m_b[3] + (ls - s1); m_b[5] = m_b[4] + (lf - f1);
  endtask

  function automatic logic [2:0] model_want(int c); // R3
    if (c < m_b[0]) return 3'b000;
    if (c < m_b[1]) return m_first;
    if (c < m_b[2]) return m_second;
    if (c < m_b[3]) return 3'b111;
    if (c < m_b[4]) return m_second;
    if (c < m_b[5]) return m_first;
    return 3'b000;
  endfunction

  task automatic check_outputs();
    logic [2:0] eh, el;
    for (int i = 0; i < 3; i++) begin
      eh[i] = m_app[i] && (m_dc[i] == 0);
      el[i] = !m_app[i] && (m_dc[i] == 0);
    end
    n_run++;
    if (gate_hi !== eh || gate_lo !== el || cmd_ready !== (m_cnt == P - 1)) begin
      n_fail++;
      $display("FAIL %s cnt=%0d hi=%b lo=%b rdy=%b expected hi=%b lo=%b rdy=%b",
               tag, m_cnt, gate_hi, gate_lo, cmd_ready, eh, el, (m_cnt == P - 1));
    end
    n_run++;
    if ((gate_hi & gate_lo) !== 3'b000) begin
      n_fail++;
      $display("FAIL R10 hi=%b lo=%b expected overlap 000", gate_hi, gate_lo);
    end
  endtask

  task automatic step();
    logic [2:0] w;
    w = model_want(m_cnt);
    for (int i = 0; i < 3; i++) begin // R8
      if (w[i] != m_app[i]) begin m_app[i] = w[i]; m_dc[i] = DEAD; end
      else if (m_dc[i] > 0) m_dc[i]--;
    end
    if (cmd_valid && m_cnt == P - 1) model_latch(int'(cmd_sector), int'(cmd_ta), int'(cmd_tb));
    m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic send(int sec, int ta, int tb);
    bit acc;
    cmd_valid = 1'b1; cmd_sector = 3'(sec); cmd_ta = W'(ta); cmd_tb = W'(tb);
    do begin
      acc = (m_cnt == P - 1);
      step();
    end while (!acc);
    cmd_valid = 1'b0;
  endtask

  task automatic point(logic [2:0] eh, string req);
    n_run++;
    if (gate_hi !== eh || gate_lo !== ~eh) begin
      n_fail++;
      $display("FAIL %s hi=%b lo=%b expected hi=%b lo=%b", req, gate_hi, gate_lo, eh, ~eh);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_app = 3'b000;
    for (int i = 0; i < 3; i++) m_dc[i] = DEAD;
    model_latch(1, 0, 0);
    repeat (5) @(negedge clk);
    n_run++;
    if (gate_hi !== 3'b000 || gate_lo !== 3'b000 || cmd_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 hi=%b lo=%b rdy=%b expected 000 000 0", gate_hi, gate_lo, cmd_ready);
    end
    rst_n = 1'b1;
    tag = "R9"; idle(2 * P);

    tag = "R1"; send(1, P, 0); idle(DEAD + 3); point(3'b001, "R1");
    tag = "R2"; send(2, 0, P); idle(DEAD + 3); point(3'b010, "R2");
    tag = "R1"; send(4, P, 0); idle(DEAD + 3); point(3'b110, "R1");

    tag = "R3"; send(1, 40, 30); idle(P); send(2, 40, 30); idle(P);
    tag = "R2";
    for (int s = 1; s <= 6; s++) begin send(s, 25 + s, 15); idle(P); end

    tag = "R4"; send(5, 10, 10); idle(P); send(3, 0, 0); idle(P); send(6, 33, 0); idle(P);
    tag = "R5"; send(3, P, P); idle(P); send(4, 900, 100); idle(P); send(2, 70, 45); idle(P);
    tag = "R6"; send(0, 50, 20); idle(P); send(7, 30, 30); idle(P);

    tag = "R7"; send(1, P, 0); idle(DEAD + 3); idle(2 * P); point(3'b001, "R7");
    send(5, 20, 20); idle(P / 2);
    cmd_valid = 1'b1; cmd_sector = 3'd3; cmd_ta = W'(P); cmd_tb = '0;
    idle(10); // pending command must not alter the running period
    send(3, P, 0); idle(DEAD + 3); point(3'b010, "R7");

    tag = "R8"; send(1, 3, 3); idle(P); send(4, 1, 1); idle(P); send(2, 5, 2); idle(P);

    tag = "R3";
    for (int k = 0; k < 150; k++) begin
      idle(int'($urandom_range(0, P)));
      send(int'($urandom_range(0, 7)), int'($urandom_range(0, P + 10)),
           int'($urandom_range(0, P + 10)));
    end
    idle(P);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule